// File: doc/BRIEF.md
# Conflict-Miss Victim Buffer

This block is a small, fully associative store that sits next to a direct-mapped cache and keeps lines that cache has recently thrown out. When the primary cache misses, its controller offers one request to the block. The request carries the line address that missed and, optionally, the line that the refill will displace. Every entry is compared against the missing address at the same time. On a hit the stored line goes back to the controller and the displaced line takes over the freed slot, so no access to the lower level is needed. On a miss the block asks the lower level for the missing line and parks the displaced line in one of its own slots.

Each entry stores a whole line, its complete line address and a dirty flag. A slot with no valid line is preferred for a new line. When every slot is full, a round-robin pointer picks the line to drop, and a dirty dropped line is written to the lower level before the read is issued. The block handles one request at a time. A handshake holds off new requests until the current response has been given.

Top module: `vc_victim_buffer`

## Requirements
- R1: After reset every entry is empty, `req_ready` is 1, and `rsp_valid` and `mem_valid` are 0.
- R2: A lookup compares `req_addr` with the full stored line address of every valid entry in parallel. It hits only on an exact match, and at most one entry matches at any time.
- R3: On a hit, `rsp_valid` is 1 in the cycle right after acceptance, with `rsp_hit`=1 and with `rsp_data` and `rsp_dirty` equal to the stored line and its flag. No lower-level transfer takes place.
- R4: On a hit the returned line leaves the buffer. If `evict_valid`=1, the offered line (address, data, dirty flag) takes the same slot. If not, the slot becomes empty.
- R5: On a miss the block raises `mem_valid` with `mem_write`=0 and `mem_addr`=`req_addr`. It holds these until a cycle with `mem_ready`=1, and gives `rsp_valid` with `rsp_hit`=0 in the following cycle. With `mem_ready` high at once and no write-back, the response comes two cycles after acceptance.
- R6: On a miss with `evict_valid`=1 and at least one empty slot, the offered line goes into the lowest-numbered empty slot, and the replacement pointer does not move.
- R7: On a miss with `evict_valid`=1 and all slots full, the offered line replaces the slot named by a pointer. The pointer starts at slot 0 after reset and moves up by one, wrapping, after each such replacement.
- R8: If the line replaced under R7 is dirty, the block first writes it to the lower level (`mem_write`=1, its address and data) and only then issues the read of R5. A clean replaced line is dropped without any transfer.
- R9: `req_ready` is 0 from the cycle after acceptance until the response cycle has ended, so no second request is taken while one is in progress.
- R10: On a miss with `evict_valid`=0 nothing is stored, and a later lookup of the offered address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | ADDR_W | Line address that missed in the primary cache |
| evict_valid | input | 1 | A displaced primary line accompanies the request |
| evict_addr | input | ADDR_W | Line address of the displaced line |
| evict_data | input | LINE_W | Contents of the displaced line |
| evict_dirty | input | 1 | Displaced line is modified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | The line was found in the buffer |
| rsp_data | output | LINE_W | Line returned to the primary cache on a hit |
| rsp_dirty | output | 1 | Modified flag of the returned line |
| mem_valid | output | 1 | Lower-level transfer requested |
| mem_ready | input | 1 | Lower level accepts the transfer |
| mem_write | output | 1 | 1 = write-back, 0 = line read |
| mem_addr | output | ADDR_W | Line address of the transfer |
| mem_wdata | output | LINE_W | Line data of a write-back |

## Verification
The bench builds the block with its defaults: four entries, 12-bit line addresses and 32-bit lines. Four slots are few enough that a handful of misses fills the buffer and sends the replacement pointer through a full wrap. That brings within reach a dirty line being pushed out, a slot freed by a swap being refilled ahead of the pointer, and a removed line missing again. Stretching the lower-level handshake by a few cycles shows that the read request stays held and that the response comes after the delay.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic [1:0] {
        VC_IDLE  = 2'd0,
        VC_WB    = 2'd1,
        VC_FETCH = 2'd2,
        VC_RESP  = 2'd3
    } vc_state_e;

    // Action chosen when a request is accepted.
    typedef struct packed {
        logic hit;
        logic store;
        logic writeback;
    } vc_action_t;

    function automatic int unsigned vc_wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ADDR_W-1:0]              addr,
    output logic [ENTRIES-1:0]             hit_vec,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = valid[g] && (tags[g] == addr);
        end
    endgenerate

    assign hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid,
    input  logic               advance,
    output logic [IDX_W-1:0]   slot,
    output logic               slot_live
);
    import vc_pkg::*;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    assign any_free = ~&valid;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign slot      = any_free ? free_idx : ptr_q;
    assign slot_live = !any_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= IDX_W'(vc_wrap_inc(int'(ptr_q), ENTRIES));
        end
    end

    // R7: the pointer only moves when every slot holds a line
    assert_full_advance_R7: assert property (@(posedge clk) disable iff (rst)
        advance |-> &valid);

    // R6: the pointer stays put when no full-buffer replacement happens
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(ptr_q));

endmodule

// File: rtl/vc_victim_buffer.sv
module vc_victim_buffer #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    parameter int LINE_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic [LINE_W-1:0] evict_data,
    input  logic              evict_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata
);
    import vc_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] data_q;
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             dirty_q;

    vc_state_e         state_q;
    logic [ADDR_W-1:0] fetch_addr_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [LINE_W-1:0] wb_data_q;
    logic              rsp_hit_q;
    logic [LINE_W-1:0] rsp_data_q;
    logic              rsp_dirty_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   slot;
    logic               slot_live;
    logic               accept;
    vc_action_t         act;
    logic [IDX_W-1:0]   dst;

    vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
        .tags(tag_q), .valid(valid_q), .addr(req_addr),
        .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
    );

    vc_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk(clk), .rst(rst), .valid(valid_q),
        .advance(accept && !hit && evict_valid && slot_live),
        .slot(slot), .slot_live(slot_live)
    );

    assign req_ready = (state_q == VC_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        act.hit       = hit;
        act.store     = evict_valid;
        act.writeback = !hit && evict_valid && valid_q[slot] && dirty_q[slot];
        dst           = hit ? hit_idx : slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q        <= '0;
            data_q       <= '0;
            valid_q      <= '0;
            dirty_q      <= '0;
            state_q      <= VC_IDLE;
            fetch_addr_q <= '0;
            wb_addr_q    <= '0;
            wb_data_q    <= '0;
            rsp_hit_q    <= 1'b0;
            rsp_data_q   <= '0;
            rsp_dirty_q  <= 1'b0;
        end else begin
            case (state_q)
                VC_IDLE: if (accept) begin
                    rsp_hit_q    <= act.hit;
                    rsp_data_q   <= act.hit ? data_q[hit_idx] : '0;
                    rsp_dirty_q  <= act.hit && dirty_q[hit_idx];
                    fetch_addr_q <= req_addr;
                    wb_addr_q    <= tag_q[slot];
                    wb_data_q    <= data_q[slot];
                    if (act.store) begin
                        tag_q[dst]   <= evict_addr;
                        data_q[dst]  <= evict_data;
                        dirty_q[dst] <= evict_dirty;
                        valid_q[dst] <= 1'b1;
                    end else if (act.hit) begin
                        valid_q[hit_idx] <= 1'b0;
                    end
                    if (act.hit)            state_q <= VC_RESP;
                    else if (act.writeback) state_q <= VC_WB;
                    else                    state_q <= VC_FETCH;
                end
                VC_WB:    if (mem_ready) state_q <= VC_FETCH;
                VC_FETCH: if (mem_ready) state_q <= VC_RESP;
                default:  state_q <= VC_IDLE;
            endcase
        end
    end

    assign rsp_valid = (state_q == VC_RESP);
    assign rsp_hit   = rsp_hit_q;
    assign rsp_data  = rsp_data_q;
    assign rsp_dirty = rsp_dirty_q;
    assign mem_valid = (state_q == VC_WB) || (state_q == VC_FETCH);
    assign mem_write = (state_q == VC_WB);
    assign mem_addr  = (state_q == VC_WB) ? wb_addr_q : fetch_addr_q;
    assign mem_wdata = wb_data_q;

    // R2: stored line addresses never alias, so at most one comparator fires
    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R3: an accepted hit answers next cycle without touching the lower level
    assert_hit_answer_R3: assert property (@(posedge clk) disable iff (rst)
        accept && hit |=> rsp_valid && rsp_hit && !mem_valid);

    // R5: a pending lower-level transfer holds its fields until taken
    assert_mem_hold_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // R9: a taken request blocks the next one
    assert_busy_stall_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

endmodule

// File: tb/test_vc_victim_buffer.sv
module test_vc_victim_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic [LW-1:0] evict_data = '0;
    logic          evict_dirty = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_dirty;
    logic [LW-1:0] rsp_data;
    logic          mem_valid, mem_write;
    logic          mem_ready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;

    int checks = 0;
    int failures = 0;

    logic          got_hit, got_dirty;
    logic [LW-1:0] got_data;
    int            lat, rd_cnt, wb_cnt, busy_bad;
    logic [AW-1:0] rd_a, wb_a;
    logic [LW-1:0] wb_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_victim_buffer #(.ENTRIES(4), .ADDR_W(AW), .LINE_W(LW)) i_vc_victim_buffer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .evict_data(evict_data), .evict_dirty(evict_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        return {a, 20'h5A5A5} ^ {20'h0, a};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One lookup; the lower level answers after 'delay' extra cycles.
    task automatic do_req(input logic [AW-1:0] a, input logic ev, input logic [AW-1:0] ea,
                          input logic ed, input int delay);
        int waitc;
        bit done;
        waitc = 0; done = 0;
        got_hit = 0; got_dirty = 0; got_data = '0;
        lat = -1; rd_cnt = 0; wb_cnt = 0; busy_bad = 0;
        rd_a = '0; wb_a = '0; wb_d = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        evict_valid = ev; evict_addr = ea; evict_data = line_of(ea); evict_dirty = ed;
        @(negedge clk);
        req_valid = 1'b0; evict_valid = 1'b0;
        for (int n = 0; n < 60 && !done; n++) begin
            if (req_ready) busy_bad++;
            if (rsp_valid) begin
                got_hit = rsp_hit; got_data = rsp_data; got_dirty = rsp_dirty;
                lat = n; done = 1; mem_ready = 1'b0;
            end else if (mem_valid) begin
                if (waitc < delay) begin
                    mem_ready = 1'b0; waitc++;
                end else begin
                    mem_ready = 1'b1; waitc = 0;
                    if (mem_write) begin
                        wb_cnt++; wb_a = mem_addr; wb_d = mem_wdata;
                    end else begin
                        rd_cnt++; rd_a = mem_addr;
                    end
                end
            end else begin
                mem_ready = 1'b0;
            end
            if (!done) @(negedge clk);
        end
        if (!done) chk("R9 response timeout", 0, 1);
    endtask

    task automatic t_reset();
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_valid", mem_valid, 0);
    endtask

    task automatic t_miss_no_store();
        do_req(12'h111, 1'b0, 12'h222, 1'b0, 0);
        chk("R5 miss hit flag", got_hit, 0);
        chk("R5 read count", rd_cnt, 1);
        chk("R5 read addr", rd_a, 12'h111);
        chk("R5 latency", lat, 1);
        chk("R9 busy stall", busy_bad, 0);
        do_req(12'h222, 1'b0, 12'h0, 1'b0, 0);
        chk("R10 offered line not stored", got_hit, 0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) begin
            do_req(12'h900 + AW'(i), 1'b1, 12'h010 * AW'(i + 1), 1'b0, 0);
            chk("R6 fill miss", got_hit, 0);
            chk("R6 fill no writeback", wb_cnt, 0);
        end
    endtask

    task automatic t_hit_swap();
        do_req(12'h030, 1'b1, 12'h500, 1'b1, 0);
        chk("R3 hit flag", got_hit, 1);
        chk("R3 hit data", got_data, line_of(12'h030));
        chk("R3 hit dirty", got_dirty, 0);
        chk("R3 hit latency", lat, 0);
        chk("R3 no lower access", rd_cnt + wb_cnt, 0);
        do_req(12'h500, 1'b0, 12'h0, 1'b0, 0);
        chk("R4 swapped line hit", got_hit, 1);
        chk("R4 swapped line data", got_data, line_of(12'h500));
        chk("R4 swapped line dirty", got_dirty, 1);
        do_req(12'h030, 1'b1, 12'h600, 1'b0, 2);
        chk("R4 returned line gone", got_hit, 0);
        chk("R5 delayed read addr", rd_a, 12'h030);
        chk("R5 delayed latency", lat, 3);
    endtask

    task automatic t_round_robin();
        do_req(12'h910, 1'b1, 12'h700, 1'b1, 0);
        chk("R7 replace slot0 clean", wb_cnt, 0);
        do_req(12'h911, 1'b1, 12'h710, 1'b0, 0);
        do_req(12'h912, 1'b1, 12'h720, 1'b0, 0);
        do_req(12'h913, 1'b1, 12'h730, 1'b0, 0);
        chk("R8 clean drop no write", wb_cnt, 0);
        do_req(12'h914, 1'b1, 12'h740, 1'b0, 0);
        chk("R8 writeback count", wb_cnt, 1);
        chk("R8 writeback addr", wb_a, 12'h700);
        chk("R8 writeback data", wb_d, line_of(12'h700));
        chk("R8 read after writeback", rd_a, 12'h914);
        chk("R8 latency with writeback", lat, 2);
        do_req(12'h010, 1'b0, 12'h0, 1'b0, 0);
        chk("R7 oldest line replaced", got_hit, 0);
        do_req(12'h600, 1'b0, 12'h0, 1'b0, 0);
        chk("R7 wrapped replacement", got_hit, 0);
        do_req(12'h740, 1'b0, 12'h0, 1'b0, 0);
        chk("R7 newest line present", got_hit, 1);
        do_req(12'h920, 1'b1, 12'h750, 1'b1, 0);
        chk("R6 free slot before pointer", wb_cnt, 0);
        do_req(12'h710, 1'b0, 12'h0, 1'b0, 0);
        chk("R6 pointer slot kept", got_hit, 1);
        chk("R2 exact address data", got_data, line_of(12'h710));
        do_req(12'h750, 1'b0, 12'h0, 1'b0, 0);
        chk("R6 refilled slot hit", got_hit, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_miss_no_store();
        t_fill();
        t_hit_swap();
        t_round_robin();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule